// File: doc/BRIEF.md
# Virtually Indexed, Physically Tagged L1 Data Cache Lookup

This block is the lookup stage of a level-one data cache. The set index and the line offset fit entirely inside the untranslated page offset of a virtual address, so the set can be read as soon as the request arrives. Address translation runs in parallel in a separate unit. One cycle later that unit delivers the physical page number, and the block compares it against the tags held for the chosen set.

The default geometry is 64 sets of 8 ways with 64-byte lines, and each line carries a 40-bit physical page number as its tag. A fill port installs a tag, a valid flag and a whole line into one way of one set. The miss path, coherence and write-back of dirty lines are handled elsewhere.

If the page number is late, the request waits in the compare stage. It keeps the set contents it captured, and the block refuses new requests until the compare completes.

Top module: `vipt_l1_lookup`

## Requirements
- R1: After a synchronous active-low reset, `rsp_valid` is 0, `req_ready` is 1 and every line is invalid, so any lookup misses.
- R2: The set is chosen by `req_voff[OFF_W+IDX_W-1:OFF_W]` and the line offset by `req_voff[OFF_W-1:0]`, where OFF_W = log2(line bytes) and IDX_W = log2(sets).
- R3: A lookup hits when a valid line in the chosen set has a tag equal to `ppn`. `rsp_way` is then one-hot with bit k set for way k.
- R4: On a hit, `rsp_data` is 64-bit word number `req_voff[OFF_W-1:3]` of the line, where word w is line bits [64w+63:64w]. Offset bits 2:0 do not affect the result.
- R5: On a miss, `rsp_hit` is 0, and `rsp_way` and `rsp_data` are all zeros.
- R6: A request is accepted at the clock edge where `req_valid` and `req_ready` are both 1. Its response appears with `rsp_valid` = 1 for exactly one cycle, after the first later edge at which `ppn_valid` is 1.
- R7: While an accepted request waits with `ppn_valid` = 0, `req_ready` is 0 and `rsp_valid` is 0. A fill to the waiting set does not change the response that request later gets.
- R8: A fill and a lookup of the same set at the same edge: the lookup sees the contents from before the fill.
- R9: A fill with valid = 0 invalidates the line, so later lookups of that way miss.
- R10: At most one way of a set matches the page number. A multiple match is flagged by an assertion.
- R11: A request presented while `req_ready` is 0 is ignored and produces no response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Lookup request present |
| req_voff | input | OFF_W+IDX_W | Page-offset bits of the virtual address |
| req_ready | output | 1 | Block can accept a request this cycle |
| ppn_valid | input | 1 | Translated page number available |
| ppn | input | PPN_W | Physical page number from translation |
| rsp_valid | output | 1 | Response present (one cycle) |
| rsp_hit | output | 1 | Lookup hit |
| rsp_way | output | WAYS | One-hot hitting way |
| rsp_data | output | 64 | Selected 64-bit word of the line |
| fill_en | input | 1 | Install a line |
| fill_set | input | IDX_W | Set to fill |
| fill_way | input | log2(WAYS) | Way to fill |
| fill_valid | input | 1 | Valid flag written with the line |
| fill_tag | input | PPN_W | Physical page number stored as tag |
| fill_line | input | 8*line bytes | Full line contents |

## Verification
A wrong index or word-select field returns data from another set or word. This shows in the very response to the affected lookup, which comes one cycle after the page number arrives, because every line carries a pattern that encodes its set, way, word and generation. A valid flag or tag that is stored wrongly turns a hit into a miss, or a miss into a hit, on the next lookup of that set. A stall snapshot that is overwritten by a fill, or a read that sees a same-edge fill, returns the new generation instead of the old one in the delayed response. A request that should have been ignored appears as an extra response pulse in the cycle after the expected one.

// File: rtl/vipt_pkg.sv
// Package: shared constants of the lookup stage.
// Assumes 64-bit data words made of 8-bit bytes.
package vipt_pkg;
    localparam int unsigned WORD_BITS = 64;
    localparam int unsigned BYTE_BITS = 8;
    localparam int unsigned WORD_BYTE_SEL_W = $clog2(WORD_BITS / BYTE_BITS);
endpackage

// File: rtl/vipt_way_bank.sv
// One way of the cache: a per-set valid flag, a tag and a line of data.
// The read registers the valid flag, the tag and one selected word of the
// addressed set. Those outputs hold while rd_en is low, which forms the
// stall snapshot. Storage is read before a same-edge write takes effect.
// Assumes SETS is a power of two and a line holds at least two words.
module vipt_way_bank
    import vipt_pkg::*;
#(
    parameter int unsigned SETS       = 64,
    parameter int unsigned LINE_BYTES = 64,
    parameter int unsigned PPN_W      = 40
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [IDX_W-1:0]      wr_set,
    input  logic                  wr_valid,
    input  logic [PPN_W-1:0]      wr_tag,
    input  logic [LINE_W-1:0]     wr_line,
    input  logic                  rd_en,
    input  logic [IDX_W-1:0]      rd_set,
    input  logic [WSEL_W-1:0]     rd_word_sel,
    output logic                  out_valid,
    output logic [PPN_W-1:0]      out_tag,
    output logic [WORD_BITS-1:0]  out_word
);
    localparam int unsigned IDX_W  = $clog2(SETS);
    localparam int unsigned LINE_W = LINE_BYTES * BYTE_BITS;
    localparam int unsigned WSEL_W = $clog2(LINE_W / WORD_BITS);

    logic [SETS-1:0]   valid_q;
    logic [PPN_W-1:0]  tag_q  [SETS];
    logic [LINE_W-1:0] data_q [SETS];

    // Valid flags: cleared by reset, written by fills.
    always_ff @(posedge clk) begin
        if (!rst_n) valid_q <= '0;
        else if (wr_en) valid_q[wr_set] <= wr_valid;
    end

    // Tag and line storage: written by fills, no reset needed.
    always_ff @(posedge clk) begin
        if (wr_en) begin
            tag_q[wr_set]  <= wr_tag;
            data_q[wr_set] <= wr_line;
        end
    end

    // Set read into the snapshot registers; held while rd_en is low.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_tag   <= '0;
            out_word  <= '0;
        end else if (rd_en) begin
            out_valid <= valid_q[rd_set];
            out_tag   <= tag_q[rd_set];
            out_word  <= data_q[rd_set][rd_word_sel*WORD_BITS +: WORD_BITS];
        end
    end

    // R9
    fill_valid_written_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (valid_q[$past(wr_set)] == $past(wr_valid)));
endmodule

// File: rtl/vipt_tag_match.sv
// Compares the snapshot tags of all ways against the translated page number.
// Builds the one-hot hit vector and ORs the words of the matching ways.
// Assumes the fill side never installs two valid lines with the same tag
// in one set; this is checked whenever a compare completes.
module vipt_tag_match
    import vipt_pkg::*;
#(
    parameter int unsigned WAYS  = 8,
    parameter int unsigned PPN_W = 40
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          chk_en,
    input  logic [WAYS-1:0]               way_valid,
    input  logic [WAYS-1:0][PPN_W-1:0]    way_tag,
    input  logic [WAYS-1:0][WORD_BITS-1:0] way_word,
    input  logic [PPN_W-1:0]              ppn,
    output logic                          hit,
    output logic [WAYS-1:0]               hit_vec,
    output logic [WORD_BITS-1:0]          word
);
    // Per-way compare, qualified by the valid flag.
    always_comb begin
        for (int i = 0; i < WAYS; i++) begin
            hit_vec[i] = way_valid[i] && (way_tag[i] == ppn);
        end
    end

    // Word selection by OR of the masked way words (one-hot select).
    always_comb begin
        word = '0;
        for (int i = 0; i < WAYS; i++) begin
            if (hit_vec[i]) word = word | way_word[i];
        end
    end

    assign hit = |hit_vec;

    // R10
    single_way_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        chk_en |-> $onehot0(hit_vec));
endmodule

// File: rtl/vipt_l1_lookup.sv
// Lookup stage of a virtually indexed, physically tagged L1 data cache.
// Cycle 1: the set is read using page-offset bits of the virtual address.
// Cycle 2 (or later): the snapshot is compared against the page number once
// ppn_valid is high, and the result is registered onto the response.
// Assumes index plus offset bits lie inside the page offset, power-of-two
// geometry, at least two ways and lines of at least two 64-bit words.
module vipt_l1_lookup
    import vipt_pkg::*;
#(
    parameter int unsigned SETS       = 64,
    parameter int unsigned WAYS       = 8,
    parameter int unsigned LINE_BYTES = 64,
    parameter int unsigned PPN_W      = 40,
    localparam int unsigned OFF_W     = $clog2(LINE_BYTES),
    localparam int unsigned IDX_W     = $clog2(SETS),
    localparam int unsigned VOFF_W    = OFF_W + IDX_W,
    localparam int unsigned WAY_W     = $clog2(WAYS),
    localparam int unsigned LINE_W    = LINE_BYTES * 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [VOFF_W-1:0] req_voff,
    output logic              req_ready,
    input  logic              ppn_valid,
    input  logic [PPN_W-1:0]  ppn,
    output logic              rsp_valid,
    output logic              rsp_hit,
    output logic [WAYS-1:0]   rsp_way,
    output logic [63:0]       rsp_data,
    input  logic              fill_en,
    input  logic [IDX_W-1:0]  fill_set,
    input  logic [WAY_W-1:0]  fill_way,
    input  logic              fill_valid,
    input  logic [PPN_W-1:0]  fill_tag,
    input  logic [LINE_W-1:0] fill_line
);
    localparam int unsigned BSEL_W = WORD_BYTE_SEL_W;
    localparam int unsigned WSEL_W = OFF_W - BSEL_W;

    logic                           s2_valid_q;
    logic                           accept;
    logic                           fire;
    logic [IDX_W-1:0]               rd_set;
    logic [WSEL_W-1:0]              rd_word_sel;
    logic [WAYS-1:0]                way_valid;
    logic [WAYS-1:0][PPN_W-1:0]     way_tag;
    logic [WAYS-1:0][WORD_BITS-1:0] way_word;
    logic                           m_hit;
    logic [WAYS-1:0]                m_hit_vec;
    logic [WORD_BITS-1:0]           m_word;
    logic                           unused_byte_bits;

    assign rd_set           = req_voff[VOFF_W-1:OFF_W];
    assign rd_word_sel      = req_voff[OFF_W-1:BSEL_W];
    assign unused_byte_bits = ^req_voff[BSEL_W-1:0];

    // Handshake: a waiting request frees the stage when its page number arrives.
    assign req_ready = !s2_valid_q || ppn_valid;
    assign accept    = req_valid && req_ready;
    assign fire      = s2_valid_q && ppn_valid;

    // Occupancy of the compare stage.
    always_ff @(posedge clk) begin
        if (!rst_n)      s2_valid_q <= 1'b0;
        else if (accept) s2_valid_q <= 1'b1;
        else if (fire)   s2_valid_q <= 1'b0;
    end

    // One storage bank per way, each with its own snapshot registers.
    for (genvar g = 0; g < WAYS; g++) begin : g_way
        vipt_way_bank #(
            .SETS       (SETS),
            .LINE_BYTES (LINE_BYTES),
            .PPN_W      (PPN_W)
        ) bank_i (
            .clk         (clk),
            .rst_n       (rst_n),
            .wr_en       (fill_en && (fill_way == WAY_W'(g))),
            .wr_set      (fill_set),
            .wr_valid    (fill_valid),
            .wr_tag      (fill_tag),
            .wr_line     (fill_line),
            .rd_en       (accept),
            .rd_set      (rd_set),
            .rd_word_sel (rd_word_sel),
            .out_valid   (way_valid[g]),
            .out_tag     (way_tag[g]),
            .out_word    (way_word[g])
        );
    end

    vipt_tag_match #(
        .WAYS  (WAYS),
        .PPN_W (PPN_W)
    ) match_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .chk_en    (fire),
        .way_valid (way_valid),
        .way_tag   (way_tag),
        .way_word  (way_word),
        .ppn       (ppn),
        .hit       (m_hit),
        .hit_vec   (m_hit_vec),
        .word      (m_word)
    );

    // Response registers: loaded when the compare completes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_hit   <= 1'b0;
            rsp_way   <= '0;
            rsp_data  <= '0;
        end else begin
            rsp_valid <= fire;
            if (fire) begin
                rsp_hit  <= m_hit;
                rsp_way  <= m_hit_vec;
                rsp_data <= m_word;
            end
        end
    end

    // R3
    hit_way_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_hit) |-> $onehot(rsp_way));
    // R5
    miss_zero_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_hit) |-> (rsp_way == '0 && rsp_data == '0));
    // R7
    stall_snapshot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s2_valid_q && !ppn_valid) |=> ($stable(way_tag) && $stable(way_word) && $stable(way_valid)));
    // R11
    busy_no_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_ready |=> s2_valid_q);
endmodule

// File: tb/vipt_l1_lookup_tb_top.sv
module vipt_l1_lookup_tb_top;
    localparam int SETS = 4, WAYS = 4, LB = 32, PW = 8;
    localparam int WORDS = LB / 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0;
    logic [6:0] req_voff = '0;
    logic req_ready;
    logic ppn_valid = 1'b0;
    logic [PW-1:0] ppn = '0;
    logic rsp_valid, rsp_hit;
    logic [WAYS-1:0] rsp_way;
    logic [63:0] rsp_data;
    logic fill_en = 1'b0;
    logic [1:0] fill_set = '0;
    logic [1:0] fill_way = '0;
    logic fill_valid = 1'b0;
    logic [PW-1:0] fill_tag = '0;
    logic [LB*8-1:0] fill_line = '0;

    int checks = 0, errors = 0;
    bit done = 0;

    // Bench model of the contents
    bit       mv [SETS][WAYS];
    bit [7:0] mt [SETS][WAYS];
    int       mg [SETS][WAYS];

    always #2.5 clk = ~clk;

    vipt_l1_lookup #(.SETS(SETS), .WAYS(WAYS), .LINE_BYTES(LB), .PPN_W(PW)) dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_voff(req_voff),
        .req_ready(req_ready), .ppn_valid(ppn_valid), .ppn(ppn),
        .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_way(rsp_way), .rsp_data(rsp_data),
        .fill_en(fill_en), .fill_set(fill_set), .fill_way(fill_way),
        .fill_valid(fill_valid), .fill_tag(fill_tag), .fill_line(fill_line));

    function automatic logic [63:0] wd(int s, int k, int w, int g);
        return {8'(8'hC0 + g), 8'(s), 8'(k), 8'(w), 32'(32'h9E3779B9 ^ (s*977 + k*131 + w*17 + g*7))};
    endfunction

    function automatic logic [LB*8-1:0] mkline(int s, int k, int g);
        logic [LB*8-1:0] l;
        for (int w = 0; w < WORDS; w++) l[w*64 +: 64] = wd(s, k, w, g);
        return l;
    endfunction

    task automatic chk(input bit ok, input string rq, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", rq, what, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk); @(negedge clk);
    endtask

    task automatic fill(input int s, input int k, input bit v, input logic [7:0] t, input int g);
        fill_en = 1'b1; fill_set = 2'(s); fill_way = 2'(k); fill_valid = v;
        fill_tag = t; fill_line = mkline(s, k, g);
        tick();
        fill_en = 1'b0;
        mv[s][k] = v; mt[s][k] = t; mg[s][k] = g;
    endtask

    // Expected result from the model: returns hit way or -1
    function automatic int model_way(int s, logic [7:0] p);
        for (int k = 0; k < WAYS; k++) if (mv[s][k] && mt[s][k] == p) return k;
        return -1;
    endfunction

    task automatic check_rsp(input int s, input int w, input logic [7:0] p,
                             input int k_exp, input int g_exp, input string rq);
        logic [63:0] ed;
        logic [WAYS-1:0] ew;
        ed = (k_exp >= 0) ? wd(s, k_exp, w, g_exp) : 64'h0;
        ew = (k_exp >= 0) ? WAYS'(1) << k_exp : '0;
        chk(rsp_valid == 1'b1, "R6", "rsp_valid", 64'(rsp_valid), 64'h1);
        chk(rsp_hit == (k_exp >= 0), (k_exp >= 0) ? "R3" : "R5", {rq, " hit"}, 64'(rsp_hit), 64'(k_exp >= 0));
        chk(rsp_way == ew, (k_exp >= 0) ? "R3" : "R5", {rq, " way"}, 64'(rsp_way), 64'(ew));
        chk(rsp_data == ed, (k_exp >= 0) ? "R4" : "R5", {rq, " data"}, rsp_data, ed);
    endtask

    // Full lookup: request, page number one cycle later, check response (R2 field layout)
    task automatic lookup(input int s, input int w, input int b, input logic [7:0] p, input string rq);
        int k;
        k = model_way(s, p);
        req_valid = 1'b1; req_voff = 7'(s*LB + w*8 + b); ppn_valid = 1'b0;
        tick();
        req_valid = 1'b0; ppn_valid = 1'b1; ppn = p;
        tick();
        ppn_valid = 1'b0;
        check_rsp(s, w, p, k, (k >= 0) ? mg[s][k] : 0, rq);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        int old_g;
        for (int s = 0; s < SETS; s++) for (int k = 0; k < WAYS; k++) begin
            mv[s][k] = 0; mt[s][k] = 0; mg[s][k] = 0;
        end
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        // R1: reset state
        chk(rsp_valid == 1'b0, "R1", "rsp_valid after reset", 64'(rsp_valid), 64'h0);
        chk(req_ready == 1'b1, "R1", "req_ready after reset", 64'(req_ready), 64'h1);
        for (int s = 0; s < SETS; s++) lookup(s, s % WORDS, 0, 8'(s*16 + 1), "R1 empty");
        // R1: response pulse lasts one cycle
        tick();
        chk(rsp_valid == 1'b0, "R6", "rsp_valid pulse width", 64'(rsp_valid), 64'h0);

        // Fill every line with a distinct tag
        for (int s = 0; s < SETS; s++) for (int k = 0; k < WAYS; k++)
            fill(s, k, 1'b1, 8'(s*16 + k + 1), 1);

        // R2 R3 R4: sweep every set, way and word; byte bits vary
        for (int s = 0; s < SETS; s++)
            for (int k = 0; k < WAYS; k++)
                for (int w = 0; w < WORDS; w++)
                    lookup(s, w, (s + k + w) % 8, 8'(s*16 + k + 1), "R2 sweep");
        // R5: tags of other sets never hit here
        for (int s = 0; s < SETS; s++) lookup(s, 1, 3, 8'(((s + 1) % SETS)*16 + 2), "R5 foreign tag");

        // R7 R11: stall with fill to the waiting line and an ignored request
        req_valid = 1'b1; req_voff = 7'(2*LB + 1*8); ppn_valid = 1'b0;
        tick();
        old_g = mg[2][1];
        req_voff = 7'(0*LB + 3*8);
        fill_en = 1'b1; fill_set = 2'd2; fill_way = 2'd1; fill_valid = 1'b1;
        fill_tag = mt[2][1]; fill_line = mkline(2, 1, 5);
        chk(req_ready == 1'b0, "R7", "req_ready while waiting", 64'(req_ready), 64'h0);
        chk(rsp_valid == 1'b0, "R7", "rsp_valid while waiting", 64'(rsp_valid), 64'h0);
        tick();
        fill_en = 1'b0;
        chk(req_ready == 1'b0, "R7", "req_ready still waiting", 64'(req_ready), 64'h0);
        chk(rsp_valid == 1'b0, "R11", "no response to busy request", 64'(rsp_valid), 64'h0);
        tick();
        req_valid = 1'b0; ppn_valid = 1'b1; ppn = mt[2][1];
        tick();
        ppn_valid = 1'b0;
        check_rsp(2, 1, mt[2][1], 1, old_g, "R7 held snapshot");
        mg[2][1] = 5;
        tick();
        chk(rsp_valid == 1'b0, "R11", "ignored request gave no response", 64'(rsp_valid), 64'h0);
        lookup(2, 1, 0, mt[2][1], "R7 new data after stall");

        // R8: fill and lookup of the same set at the same edge
        req_valid = 1'b1; req_voff = 7'(1*LB + 2*8 + 5);
        fill_en = 1'b1; fill_set = 2'd1; fill_way = 2'd3; fill_valid = 1'b1;
        fill_tag = 8'hEE; fill_line = mkline(1, 3, 9);
        tick();
        req_valid = 1'b0; fill_en = 1'b0; ppn_valid = 1'b1; ppn = mt[1][3];
        tick();
        ppn_valid = 1'b0;
        check_rsp(1, 2, mt[1][3], 3, mg[1][3], "R8 old contents");
        mv[1][3] = 1; mt[1][3] = 8'hEE; mg[1][3] = 9;
        lookup(1, 2, 0, 8'(1*16 + 3 + 1), "R8 old tag gone");
        lookup(1, 2, 0, 8'hEE, "R8 new tag");

        // R9: invalidate a line
        fill(0, 2, 1'b0, 8'(0*16 + 2 + 1), 3);
        lookup(0, 0, 0, 8'(0*16 + 2 + 1), "R9 invalidated");
        lookup(0, 3, 7, 8'(0*16 + 1 + 1), "R9 neighbour kept");

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule